// File: doc/BRIEF.md
# DRAM Address-Map Configuration Matcher

This block chooses the address-map layout that a memory scheduler uses for a DRAM device whose column and row counts are already known. It holds sixteen fixed layout options. Each option has a column count, a row count and one of three interleave kinds. When started, it walks those options from index 0 upward, one per clock. It returns the index of the first option that fits the requested interleave kind under that kind's own fitting rule.

Boot-time configuration logic drives the detected geometry and the wanted interleave kind, pulses `start`, and waits for `done`. The option table is written for a 32-bit data bus. When `narrow_bus` is set, the block uses one column fewer than the detected count before it compares. If no option fits, `not_found` is raised together with `done`, and the previously reported index is kept.

Top module: `amap_matcher`

## Requirements
- R1: After reset, `busy`, `done`, `not_found` and `map_idx` are all 0.
- R2: Kind code 2'b00 considers only options 0 to 10. Such an option fits when its columns equal the effective columns and its rows equal the detected rows.
- R3: Kind code 2'b01 considers only options 11 to 13. Such an option fits when its columns equal the effective columns and its rows are no more than the detected rows.
- R4: Kind code 2'b10 considers only options 14 and 15. Such an option fits when its columns equal the effective columns, or when its columns are no more than the effective columns and its rows equal the detected rows.
- R5: Options are tried in ascending index order, and options of any other kind are skipped. The lowest fitting index is reported even when later options also fit.
- R6: The option geometry (index: rows/columns) is 0:13/10, 1:14/10, 2:15/10, 3:16/10, 4:14/11, 5:15/11, 6:16/11, 7:13/9, 8:14/9, 9:15/9, 10:16/9, 11:15/10, 12:14/11, 13:13/10, 14:16/10, 15:16/9. With `narrow_bus`=1, the effective column count is the detected count minus one, held at 0 when the detected count is 0. With `narrow_bus`=0 it is the detected count.
- R7: `done` is a one-cycle pulse. Count the clock edge that samples `start` as edge 0. A fit at index k raises `done` after edge k+1. When nothing fits, `done` rises after edge 16.
- R8: Kind code 2'b11 fits nothing. `done` and `not_found` rise after edge 1.
- R9: When `done` comes with `not_found`=1, `map_idx` keeps the value it had before. When `done` comes with a fit, `not_found` is 0 and `map_idx` holds the fitting index.
- R10: `busy` is 1 from the edge that samples `start` until `done` rises, and it is never 1 in the same cycle as `done`. A `start` that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search; sampled while idle |
| scheme | input | 2 | Requested interleave kind (00, 01, 10; 11 reserved) |
| narrow_bus | input | 1 | 1 when the data bus is narrower than 32 bits |
| col_cnt | input | COL_W (4) | Detected column address bit count |
| row_cnt | input | ROW_W (5) | Detected row address bit count |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| not_found | output | 1 | Last search found no fitting option |
| map_idx | output | 4 | Index of the last fitting option |

## Verification
A wrong scan index or a corrupted latched geometry shows at the ports as a wrong `map_idx` or a wrong completion cycle. Because exactly one option is tried per clock, a scan counter that is off by one moves `done` by a cycle relative to the index it reports. That is visible on the very first search that fits anywhere but the last option. A fitting rule attached to the wrong kind shows as a fit reported for an index outside that kind's range, or as a spurious `not_found`. The sweep over every kind, bus width, column count and row count catches this on the first geometry that separates the rules. A lost `not_found` hold shows as `map_idx` changing on the first failed search after a successful one.

// File: rtl/amap_pkg.sv
package amap_pkg;

   localparam int unsigned AMAP_ENTRIES = 16;
   localparam int unsigned AMAP_IDX_W   = $clog2(AMAP_ENTRIES);
   localparam int unsigned AMAP_TCOL_W  = 4;
   localparam int unsigned AMAP_TROW_W  = 5;

   // interleave kinds; code 3 fits nothing
   typedef enum logic [1:0] {
      KIND_EXACT  = 2'd0,
      KIND_ROWMIN = 2'd1,
      KIND_EITHER = 2'd2,
      KIND_NONE   = 2'd3
   } amap_kind_e;

   typedef struct packed {
      amap_kind_e             kind;
      logic [AMAP_TCOL_W-1:0] cols;
      logic [AMAP_TROW_W-1:0] rows;
   } amap_entry_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SCAN = 1'b1
   } amap_state_e;

endpackage

// File: rtl/amap_table.sv
module amap_table
   import amap_pkg::*;
(
   input  logic [AMAP_IDX_W-1:0] idx,
   output amap_entry_t           ent
);

   always_comb begin
      ent.kind = KIND_EXACT;
      ent.cols = 4'd10;
      ent.rows = 5'd13;
      case (idx)
         4'd0:  begin ent.kind = KIND_EXACT;  ent.cols = 4'd10; ent.rows = 5'd13; end
         4'd1:  begin ent.kind = KIND_EXACT;  ent.cols = 4'd10; ent.rows = 5'd14; end
         4'd2:  begin ent.kind = KIND_EXACT;  ent.cols = 4'd10; ent.rows = 5'd15; end
         4'd3:  begin ent.kind = KIND_EXACT;  ent.cols = 4'd10; ent.rows = 5'd16; end
         4'd4:  begin ent.kind = KIND_EXACT;  ent.cols = 4'd11; ent.rows = 5'd14; end
         4'd5:  begin ent.kind = KIND_EXACT;  ent.cols = 4'd11; ent.rows = 5'd15; end
         4'd6:  begin ent.kind = KIND_EXACT;  ent.cols = 4'd11; ent.rows = 5'd16; end
         4'd7:  begin ent.kind = KIND_EXACT;  ent.cols = 4'd9;  ent.rows = 5'd13; end
         4'd8:  begin ent.kind = KIND_EXACT;  ent.cols = 4'd9;  ent.rows = 5'd14; end
         4'd9:  begin ent.kind = KIND_EXACT;  ent.cols = 4'd9;  ent.rows = 5'd15; end
         4'd10: begin ent.kind = KIND_EXACT;  ent.cols = 4'd9;  ent.rows = 5'd16; end
         4'd11: begin ent.kind = KIND_ROWMIN; ent.cols = 4'd10; ent.rows = 5'd15; end
         4'd12: begin ent.kind = KIND_ROWMIN; ent.cols = 4'd11; ent.rows = 5'd14; end
         4'd13: begin ent.kind = KIND_ROWMIN; ent.cols = 4'd10; ent.rows = 5'd13; end
         4'd14: begin ent.kind = KIND_EITHER; ent.cols = 4'd10; ent.rows = 5'd16; end
         default: begin ent.kind = KIND_EITHER; ent.cols = 4'd9; ent.rows = 5'd16; end
      endcase
   end

endmodule

// File: rtl/amap_rule.sv
module amap_rule
   import amap_pkg::*;
#(
   parameter int unsigned COL_W = 4,
   parameter int unsigned ROW_W = 5
) (
   input  amap_kind_e       req_kind,
   input  amap_entry_t      ent,
   input  logic [COL_W-1:0] eff_cols,
   input  logic [ROW_W-1:0] det_rows,
   output logic             hit
);

   localparam int unsigned N_KINDS = 4;

   logic [COL_W-1:0]   t_cols;
   logic [ROW_W-1:0]   t_rows;
   logic               col_eq, col_le, row_eq, row_le;
   logic [N_KINDS-1:0] rule_hit;

   assign t_cols = COL_W'(ent.cols);
   assign t_rows = ROW_W'(ent.rows);
   assign col_eq = (t_cols == eff_cols);
   assign col_le = (t_cols <= eff_cols);
   assign row_eq = (t_rows == det_rows);
   assign row_le = (t_rows <= det_rows);

   // one fitting rule per kind code
   for (genvar k = 0; k < N_KINDS; k++) begin : g_rule
      if (k == int'(KIND_EXACT)) begin : g_exact
         assign rule_hit[k] = col_eq && row_eq;
      end else if (k == int'(KIND_ROWMIN)) begin : g_rowmin
         assign rule_hit[k] = col_eq && row_le;
      end else if (k == int'(KIND_EITHER)) begin : g_either
         assign rule_hit[k] = col_eq || (col_le && row_eq);
      end else begin : g_none
         assign rule_hit[k] = 1'b0;
      end
   end

   assign hit = (ent.kind == req_kind) && rule_hit[req_kind];

endmodule

// File: rtl/amap_matcher.sv
module amap_matcher
   import amap_pkg::*;
#(
   parameter int unsigned COL_W = 4,
   parameter int unsigned ROW_W = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [1:0]            scheme,
   input  logic                  narrow_bus,
   input  logic [COL_W-1:0]      col_cnt,
   input  logic [ROW_W-1:0]      row_cnt,
   output logic                  busy,
   output logic                  done,
   output logic                  not_found,
   output logic [AMAP_IDX_W-1:0] map_idx
);

   localparam logic [AMAP_IDX_W-1:0] LAST_IDX = AMAP_IDX_W'(AMAP_ENTRIES - 1);

   if (COL_W < AMAP_TCOL_W) begin : g_bad_col_w
      $error("amap_matcher: COL_W too small for table columns");
   end
   if (ROW_W < AMAP_TROW_W) begin : g_bad_row_w
      $error("amap_matcher: ROW_W too small for table rows");
   end

   amap_state_e           st_q;
   logic [AMAP_IDX_W-1:0] idx_q;
   amap_kind_e            kind_q;
   logic [COL_W-1:0]      cols_q;
   logic [ROW_W-1:0]      rows_q;
   logic [COL_W-1:0]      eff_cols;
   logic                  done_q, nf_q;
   logic [AMAP_IDX_W-1:0] map_q;
   amap_entry_t           ent;
   logic                  hit;

   // narrow bus consumes one column bit; saturate at zero
   assign eff_cols = (narrow_bus && (col_cnt != '0)) ? col_cnt - 1'b1 : col_cnt;

   amap_table i_table (
      .idx (idx_q),
      .ent (ent)
   );

   amap_rule #(
      .COL_W (COL_W),
      .ROW_W (ROW_W)
   ) i_rule (
      .req_kind (kind_q),
      .ent      (ent),
      .eff_cols (cols_q),
      .det_rows (rows_q),
      .hit      (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         kind_q <= KIND_EXACT;
         cols_q <= '0;
         rows_q <= '0;
         done_q <= 1'b0;
         nf_q   <= 1'b0;
         map_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q   <= ST_SCAN;
                  idx_q  <= '0;
                  kind_q <= amap_kind_e'(scheme);
                  cols_q <= eff_cols;
                  rows_q <= row_cnt;
               end
            end
            default: begin
               if (hit) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                  nf_q   <= 1'b0;
                  map_q  <= idx_q;
               end else if ((kind_q == KIND_NONE) || (idx_q == LAST_IDX)) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                  nf_q   <= 1'b1;
               end else begin
                  idx_q  <= idx_q + 1'b1;
               end
            end
         endcase
      end
   end

   assign busy      = (st_q == ST_SCAN);
   assign done      = done_q;
   assign not_found = nf_q;
   assign map_idx   = map_q;

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   p_start_takes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   p_busy_ends_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));

   p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && not_found) |-> $stable(map_idx));

   p_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (kind_q == KIND_NONE)) |=> (done && not_found));

endmodule

// File: tb/test_amap_matcher.sv
module test_amap_matcher;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] scheme = 2'd0;
   logic       narrow = 1'b0;
   logic [3:0] col = 4'd0;
   logic [4:0] row = 5'd0;
   logic       busy, done, nf;
   logic [3:0] midx;

   int total = 0;
   int bad = 0;
   int prev_idx = 0;

   always #2 clk = ~clk;

   amap_matcher i_amap_matcher (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .scheme     (scheme),
      .narrow_bus (narrow),
      .col_cnt    (col),
      .row_cnt    (row),
      .busy       (busy),
      .done       (done),
      .not_found  (nf),
      .map_idx    (midx)
   );

   // geometry from R6
   function automatic int tb_rows(int i);
      case (i)
         0, 7, 13:               return 13;
         1, 4, 8, 12:            return 14;
         2, 5, 9, 11:            return 15;
         default:                return 16;
      endcase
   endfunction

   function automatic int tb_cols(int i);
      if (i >= 7 && i <= 10) return 9;
      if (i == 15) return 9;
      if (i == 4 || i == 5 || i == 6 || i == 12) return 11;
      return 10;
   endfunction

   function automatic int tb_kind(int i);
      if (i <= 10) return 0;
      if (i <= 13) return 1;
      return 2;
   endfunction

   function automatic int ref_find(int k, int c, int r);
      if (k == 3) return 16;
      for (int i = 0; i < 16; i++) begin
         bit m;
         if (tb_kind(i) != k) continue;
         if (k == 0)      m = (tb_cols(i) == c) && (tb_rows(i) == r);
         else if (k == 1) m = (tb_cols(i) == c) && (tb_rows(i) <= r);
         else             m = (tb_cols(i) == c) || ((tb_cols(i) <= c) && (tb_rows(i) == r));
         if (m) return i;
      end
      return 16;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run(input int k, input int n, input int c, input int r,
                      output int ri, output int rn, output int rl, output int rb);
      @(negedge clk);
      scheme = 2'(k); narrow = 1'(n); col = 4'(c); row = 5'(r); start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      rb = int'(busy);
      rl = 0;
      while (rl < 40) begin
         @(posedge clk);
         rl++;
         @(negedge clk);
         if (done) break;
      end
      ri = int'(midx);
      rn = int'(nf);
   endtask

   task automatic do_case(input int k, input int n, input int c, input int r, input string extra);
      int ri, rn, rl, rb, eff, exp, e_lat, e_nf, e_idx;
      string tag;
      eff   = (n != 0 && c > 0) ? c - 1 : c;
      exp   = ref_find(k, eff, r);
      e_nf  = (exp == 16) ? 1 : 0;
      e_idx = e_nf ? prev_idx : exp;
      e_lat = (k == 3) ? 1 : (e_nf ? 16 : exp + 1);
      tag = (k == 0) ? "R2" : (k == 1) ? "R3" : (k == 2) ? "R4" : "R8";
      if (n != 0) tag = {tag, "/R6"};
      if (e_nf != 0) tag = {tag, "/R9"};
      tag = {tag, extra};
      run(k, n, c, r, ri, rn, rl, rb);
      chk((ri == e_idx) && (rn == e_nf), {tag, " idx+100*nf"}, ri + 100 * rn, e_idx + 100 * e_nf);
      chk(rl == e_lat, {"R7 latency ", tag}, rl, e_lat);
      chk(rb == 1, "R10 busy after start", rb, 1);
      prev_idx = e_idx;
   endtask

   initial begin : watchdog
      #720000;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int ri, rn, rl, rb;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0 && nf == 1'b0 && midx == 4'd0,
          "R1 reset state", int'({busy, done, nf, midx}), 0);
      rst_n = 1'b1;

      // R5: several options fit, lowest wins; foreign kinds skipped
      do_case(2, 0, 10, 16, " R5 first of 14/15");
      do_case(1, 0, 10, 16, " R5 skip kind0 entry 3");
      do_case(1, 0, 10, 13, " R5 entry 13 only");
      // R6 saturation: narrow with zero columns must not wrap
      do_case(2, 1, 0, 16, " R6 saturate");
      do_case(0, 1, 11, 13, " R6 narrow exact");

      // R10: start during scan ignored
      @(negedge clk);
      scheme = 2'd0; narrow = 1'b0; col = 4'd0; row = 5'd0; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      rl = 0;
      repeat (2) begin
         @(posedge clk); rl++; @(negedge clk);
      end
      scheme = 2'd0; col = 4'd10; row = 5'd13; start = 1'b1;
      @(posedge clk); rl++; @(negedge clk);
      start = 1'b0;
      while (rl < 40 && !done) begin
         @(posedge clk); rl++; @(negedge clk);
      end
      chk(nf == 1'b1 && int'(midx) == prev_idx, "R10 ignored start result",
          int'(nf) * 100 + int'(midx), 100 + prev_idx);
      chk(rl == 16, "R10 ignored start latency", rl, 16);

      // exhaustive sweep
      for (int k = 0; k < 4; k++)
         for (int n = 0; n < 2; n++)
            for (int c = 0; c < 16; c++)
               for (int r = 0; r < 32; r++)
                  do_case(k, n, c, r, "");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule